// File: doc/BRIEF.md
# Branch Target Selector

This block sits in the fetch stage. For each control instruction it is shown, it decides whether the instruction is predicted taken and chooses the next fetch address. A conditional instruction gets its direction from an external direction predictor. An unconditional instruction is always taken. The structures inside the block can still demote a taken prediction to not-taken. A return with an empty return stack is demoted, and so is a branch whose target is not in the target buffer.

There is one return address stack per thread and one shared tagged branch target buffer. The buffer is written through its own update port. For every request the block drives the predicted next PC and a history record. The record carries the sequence number, the PC, the thread, the final direction, whether the stack was pushed or popped, and for a pop the slot index and the value read. A later repair stage uses the record, and the queue that holds the records lives outside this block. Predictions are combinational from the request. The stack and buffer contents change at the clock edge that ends the request cycle.

Top module: `bts_unit`

## Requirements
- R1: After reset every return stack is empty and every buffer entry is invalid. A return is then predicted not-taken and a buffer lookup misses.
- R2: A request with isUncond=1 is predicted taken before any demotion, and dirTaken has no effect on it.
- R3: A request with isCond=1 and isUncond=0 takes its direction from dirTaken. A request with neither flag set is predicted not-taken.
- R4: A taken return predicts the value at the top of its thread's stack and pops that stack. The record has histUsedRas=1, and histRasIdx and histRasTarget hold the slot index and the value read.
- R5: A return whose thread's stack is empty is predicted not-taken. The stack is not popped and histUsedRas=0.
- R6: A call that is taken before any demotion pushes its own PC and sets histPushedRas=1. This happens even when a buffer miss then demotes the call to not-taken.
- R7: A call with isUncond=1 and isDirect=1 predicts directTarget, even when the buffer holds a different target for its PC.
- R8: Every other taken instruction that is not a return looks up the buffer. A hit needs a valid entry at index reqPc[7:2], a stored PC equal to reqPc in every bit, and a stored address-space ID equal to reqAsid. A miss makes the prediction not-taken.
- R9: Each stack has 16 slots used as a ring. The first push after reset goes into slot 0, each push advances the top index by one modulo 16, and each pop moves it back by one. A push onto a full stack overwrites the oldest entry, and the occupancy stays at 16.
- R10: Whenever the final prediction is not-taken, predPc equals reqPc + 4.
- R11: A buffer write presented on the update port is visible from the next cycle on. A lookup in the same cycle as the write sees the old contents.
- R12: histValid follows reqValid. histSeq, histPc and histTid repeat the request, and histTaken equals predTaken. When no pop happens, histRasIdx and histRasTarget are zero.
- R13: The stacks of different threads are independent. A push or pop on one thread leaves every other thread's stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A control instruction is presented this cycle |
| reqPc | input | 32 | PC of the instruction |
| isUncond | input | 1 | Unconditional control class |
| isCond | input | 1 | Conditional control class |
| isCall | input | 1 | Instruction is a call |
| isReturn | input | 1 | Instruction is a return |
| isDirect | input | 1 | Target is encoded in the instruction |
| directTarget | input | 32 | Decoded direct target |
| reqAsid | input | 8 | Address-space ID of the request |
| reqTid | input | 1 | Thread of the request |
| reqSeq | input | 16 | Sequence number of the request |
| dirTaken | input | 1 | Direction from the external conditional predictor |
| updValid | input | 1 | Write one buffer entry |
| updPc | input | 32 | PC of the entry being written |
| updAsid | input | 8 | Address-space ID of the entry being written |
| updTarget | input | 32 | Target of the entry being written |
| predTaken | output | 1 | Final predicted direction |
| predPc | output | 32 | Predicted next PC |
| histValid | output | 1 | History record valid |
| histTid | output | 1 | Thread of the record |
| histSeq | output | 16 | Sequence number of the record |
| histPc | output | 32 | PC of the record |
| histTaken | output | 1 | Direction in the record |
| histUsedRas | output | 1 | The stack was popped |
| histPushedRas | output | 1 | The stack was pushed |
| histRasIdx | output | 4 | Stack slot that was popped |
| histRasTarget | output | 32 | Value read from the popped slot |

## Verification
The clash that matters is a buffer write and a buffer lookup of the same PC in the same cycle. The bench stages this by writing a new entry while, in that same cycle, it presents an indirect jump to the PC being written. It expects a miss with the sequential PC in that cycle and a hit with the written target in the next cycle. The random phase keeps the update port busy about a third of the time over a small pool of PCs that alias on index, so the clash also comes up in mixed traffic. The bench model applies each write only after that cycle's lookup has been checked.

// File: rtl/bts_pkg.sv
`timescale 1ns/1ps
package bts_pkg;
  // strobes from control to datapath for one request
  typedef struct packed {
    logic push;       // push reqPc on the request's thread stack
    logic pop;        // pop the request's thread stack
    logic selDirect;  // target is the decoded direct target
    logic selRas;     // target is the stack top
    logic taken;      // final direction; buffer target when no other select
  } btsStrobe_t;
endpackage

// File: rtl/bts_ras.sv
`timescale 1ns/1ps
module bts_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushVal,
  output logic [ADDR_W-1:0] topVal,
  output logic [IDX_W-1:0]  topIdx,
  output logic              empty
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  topPtr;
  logic [CNT_W-1:0]  fill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr <= IDX_W'(DEPTH - 1);
      fill   <= '0;
    end else if (push) begin
      topPtr <= topPtr + IDX_W'(1);
      fill   <= (fill == CNT_W'(DEPTH)) ? fill : fill + CNT_W'(1);
    end else if (pop) begin
      topPtr <= topPtr - IDX_W'(1);
      fill   <= fill - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[topPtr + IDX_W'(1)] <= pushVal;
  end

  assign topVal = mem[topPtr];
  assign topIdx = topPtr;
  assign empty  = (fill == '0);
endmodule

// File: rtl/bts_btb.sv
`timescale 1ns/1ps
module bts_btb #(
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 64,
  parameter int OFF_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupPc,
  input  logic [ASID_W-1:0] lookupAsid,
  output logic              hit,
  output logic [ADDR_W-1:0] target,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ASID_W-1:0] updAsid,
  input  logic [ADDR_W-1:0] updTarget
);
  // the tag is the whole PC, so misaligned PCs never alias
  logic [ENTRIES-1:0] valid;
  logic [ADDR_W-1:0]  tagMem  [ENTRIES];
  logic [ASID_W-1:0]  asidMem [ENTRIES];
  logic [ADDR_W-1:0]  tgtMem  [ENTRIES];

  logic [IDX_W-1:0] lIdx, uIdx;
  assign lIdx = lookupPc[OFF_W +: IDX_W];
  assign uIdx = updPc[OFF_W +: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valid <= '0;
    else if (updValid) valid[uIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (updValid) begin
      tagMem[uIdx]  <= updPc;
      asidMem[uIdx] <= updAsid;
      tgtMem[uIdx]  <= updTarget;
    end
  end

  assign hit    = valid[lIdx] && (tagMem[lIdx] == lookupPc) && (asidMem[lIdx] == lookupAsid);
  assign target = tgtMem[lIdx];
endmodule

// File: rtl/bts_ctrl.sv
`timescale 1ns/1ps
module bts_ctrl
  import bts_pkg::*;
(
  input  logic       reqValid,
  input  logic       isUncond,
  input  logic       isCond,
  input  logic       isCall,
  input  logic       isReturn,
  input  logic       isDirect,
  input  logic       dirTaken,
  input  logic       rasEmpty,
  input  logic       btbHit,
  output btsStrobe_t strb
);
  logic firstTaken;

  always_comb begin
    strb = '0;
    firstTaken = isUncond ? 1'b1 : (isCond && dirTaken);
    if (isReturn && rasEmpty) firstTaken = 1'b0;
    if (reqValid && firstTaken) begin
      if (isReturn) begin
        strb.pop    = 1'b1;
        strb.selRas = 1'b1;
        strb.taken  = 1'b1;
      end else begin
        strb.push = isCall;
        if (isCall && isUncond && isDirect) begin
          strb.selDirect = 1'b1;
          strb.taken     = 1'b1;
        end else if (btbHit) begin
          strb.taken = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bts_datapath.sv
`timescale 1ns/1ps
module bts_datapath
  import bts_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int THREADS     = 2,
  parameter int RAS_DEPTH   = 16,
  parameter int BTB_ENTRIES = 64,
  parameter int INST_BYTES  = 4,
  localparam int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RIDX_W     = $clog2(RAS_DEPTH),
  localparam int OFF_W      = $clog2(INST_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  btsStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqPc,
  input  logic [TID_W-1:0]  reqTid,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [ADDR_W-1:0] directTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ASID_W-1:0] updAsid,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              rasEmpty,
  output logic              btbHit,
  output logic [ADDR_W-1:0] predPc,
  output logic [RIDX_W-1:0] rasIdx,
  output logic [ADDR_W-1:0] rasTarget
);
  logic [ADDR_W-1:0] topValA [THREADS];
  logic [RIDX_W-1:0] topIdxA [THREADS];
  logic [THREADS-1:0] emptyA;
  logic [ADDR_W-1:0] btbTarget;

  for (genvar t = 0; t < THREADS; t++) begin : g_ras
    bts_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
      .clk     (clk),
      .rstN    (rstN),
      .push    (strb.push && (reqTid == TID_W'(t))),
      .pop     (strb.pop && (reqTid == TID_W'(t))),
      .pushVal (reqPc),
      .topVal  (topValA[t]),
      .topIdx  (topIdxA[t]),
      .empty   (emptyA[t])
    );
  end

  bts_btb #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .ENTRIES(BTB_ENTRIES), .OFF_W(OFF_W)) u_btb (
    .clk        (clk),
    .rstN       (rstN),
    .lookupPc   (reqPc),
    .lookupAsid (reqAsid),
    .hit        (btbHit),
    .target     (btbTarget),
    .updValid   (updValid),
    .updPc      (updPc),
    .updAsid    (updAsid),
    .updTarget  (updTarget)
  );

  assign rasEmpty  = emptyA[reqTid];
  assign rasIdx    = strb.pop ? topIdxA[reqTid] : '0;
  assign rasTarget = strb.pop ? topValA[reqTid] : '0;

  always_comb begin
    if (!strb.taken)        predPc = reqPc + ADDR_W'(INST_BYTES);
    else if (strb.selRas)   predPc = topValA[reqTid];
    else if (strb.selDirect) predPc = directTarget;
    else                    predPc = btbTarget;
  end
endmodule

// File: rtl/bts_unit.sv
`timescale 1ns/1ps
module bts_unit
  import bts_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int THREADS     = 2,
  parameter int SEQ_W       = 16,
  parameter int RAS_DEPTH   = 16,
  parameter int BTB_ENTRIES = 64,
  parameter int INST_BYTES  = 4,
  localparam int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int RIDX_W     = $clog2(RAS_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqPc,
  input  logic              isUncond,
  input  logic              isCond,
  input  logic              isCall,
  input  logic              isReturn,
  input  logic              isDirect,
  input  logic [ADDR_W-1:0] directTarget,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [TID_W-1:0]  reqTid,
  input  logic [SEQ_W-1:0]  reqSeq,
  input  logic              dirTaken,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ASID_W-1:0] updAsid,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predPc,
  output logic              histValid,
  output logic [TID_W-1:0]  histTid,
  output logic [SEQ_W-1:0]  histSeq,
  output logic [ADDR_W-1:0] histPc,
  output logic              histTaken,
  output logic              histUsedRas,
  output logic              histPushedRas,
  output logic [RIDX_W-1:0] histRasIdx,
  output logic [ADDR_W-1:0] histRasTarget
);
  btsStrobe_t strb;
  logic rasEmptySel;
  logic btbHit;

  bts_ctrl u_ctrl (
    .reqValid (reqValid),
    .isUncond (isUncond),
    .isCond   (isCond),
    .isCall   (isCall),
    .isReturn (isReturn),
    .isDirect (isDirect),
    .dirTaken (dirTaken),
    .rasEmpty (rasEmptySel),
    .btbHit   (btbHit),
    .strb     (strb)
  );

  bts_datapath #(
    .ADDR_W(ADDR_W), .ASID_W(ASID_W), .THREADS(THREADS),
    .RAS_DEPTH(RAS_DEPTH), .BTB_ENTRIES(BTB_ENTRIES), .INST_BYTES(INST_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqPc        (reqPc),
    .reqTid       (reqTid),
    .reqAsid      (reqAsid),
    .directTarget (directTarget),
    .updValid     (updValid),
    .updPc        (updPc),
    .updAsid      (updAsid),
    .updTarget    (updTarget),
    .rasEmpty     (rasEmptySel),
    .btbHit       (btbHit),
    .predPc       (predPc),
    .rasIdx       (histRasIdx),
    .rasTarget    (histRasTarget)
  );

  assign predTaken     = strb.taken;
  assign histTaken     = strb.taken;
  assign histValid     = reqValid;
  assign histTid       = reqTid;
  assign histSeq       = reqSeq;
  assign histPc        = reqPc;
  assign histUsedRas   = strb.pop;
  assign histPushedRas = strb.push;
endmodule

// File: rtl/bts_checker.sv
`timescale 1ns/1ps
module bts_checker #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              isUncond,
  input logic              isCall,
  input logic              isReturn,
  input logic              isDirect,
  input logic [ADDR_W-1:0] reqPc,
  input logic [ADDR_W-1:0] directTarget,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predPc,
  input logic              histUsedRas,
  input logic              push,
  input logic              pop,
  input logic              rasEmpty
);
  a_r4_pop_only_taken_return: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (reqValid && isReturn && predTaken && histUsedRas));

  a_r5_empty_return_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isReturn && rasEmpty) |-> (!predTaken && !pop));

  a_r7_direct_call_target: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isUncond && isCall && isDirect && !isReturn) |-> (predTaken && push && predPc == directTarget));

  a_r10_not_taken_sequential: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !predTaken) |-> (predPc == reqPc + ADDR_W'(INST_BYTES)));

  a_r6_push_needs_call: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (reqValid && isCall && !pop));

  a_r2_uncond_nonreturn_taken_or_demoted: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isUncond && isCall) |-> push);
endmodule

bind bts_unit bts_checker #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .isUncond     (isUncond),
  .isCall       (isCall),
  .isReturn     (isReturn),
  .isDirect     (isDirect),
  .reqPc        (reqPc),
  .directTarget (directTarget),
  .predTaken    (predTaken),
  .predPc       (predPc),
  .histUsedRas  (histUsedRas),
  .push         (strb.push),
  .pop          (strb.pop),
  .rasEmpty     (rasEmptySel)
);

// File: tb/bts_unit_tb_top.sv
`timescale 1ns/1ps
module bts_unit_tb_top;
  localparam int ADDR_W = 32, ASID_W = 8, THREADS = 2, SEQ_W = 16;
  localparam int RAS_DEPTH = 16, BTB_ENTRIES = 64, INST_BYTES = 4;

  localparam int K_COND = 0, K_JMP_D = 1, K_JMP_I = 2, K_CALL_D = 3,
                 K_CALL_I = 4, K_RET = 5, K_CRET = 6, K_CCALL = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, isUncond, isCond, isCall, isReturn, isDirect, dirTaken;
  logic [31:0] reqPc, directTarget, updPc, updTarget;
  logic [7:0]  reqAsid, updAsid;
  logic [0:0]  reqTid;
  logic [15:0] reqSeq;
  logic updValid;
  logic predTaken, histValid, histTaken, histUsedRas, histPushedRas;
  logic [31:0] predPc, histPc, histRasTarget;
  logic [0:0]  histTid;
  logic [15:0] histSeq;
  logic [3:0]  histRasIdx;

  bts_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPc(reqPc),
    .isUncond(isUncond), .isCond(isCond), .isCall(isCall), .isReturn(isReturn),
    .isDirect(isDirect), .directTarget(directTarget), .reqAsid(reqAsid),
    .reqTid(reqTid), .reqSeq(reqSeq), .dirTaken(dirTaken),
    .updValid(updValid), .updPc(updPc), .updAsid(updAsid), .updTarget(updTarget),
    .predTaken(predTaken), .predPc(predPc), .histValid(histValid), .histTid(histTid),
    .histSeq(histSeq), .histPc(histPc), .histTaken(histTaken),
    .histUsedRas(histUsedRas), .histPushedRas(histPushedRas),
    .histRasIdx(histRasIdx), .histRasTarget(histRasTarget)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int seqCtr = 0;

  // reference model state
  logic [31:0] mStk [THREADS][RAS_DEPTH];
  int mTop [THREADS];
  int mCnt [THREADS];
  bit          mV  [BTB_ENTRIES];
  logic [31:0] mPc [BTB_ENTRIES];
  logic [7:0]  mAs [BTB_ENTRIES];
  logic [31:0] mTg [BTB_ENTRIES];

  // pending update for the next request cycle
  bit pUpd = 0;
  logic [31:0] pPc, pTg;
  logic [7:0]  pAs;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bIdx(logic [31:0] pc);
    return int'((pc / INST_BYTES) % BTB_ENTRIES);
  endfunction

  function automatic bit mHit(logic [31:0] pc, logic [7:0] as);
    int i = bIdx(pc);
    return mV[i] && mPc[i] == pc && mAs[i] == as;
  endfunction

  task automatic setUpd(logic [31:0] pc, logic [7:0] as, logic [31:0] tg);
    pUpd = 1; pPc = pc; pAs = as; pTg = tg;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; updValid = 0;
  endtask

  task automatic doReq(string tag, int kind, logic [31:0] pc, logic [31:0] dt,
                       logic [7:0] as, int tid, bit dirT);
    bit unc, cnd, cal, ret, dir;
    bit tk, pop, push;
    logic [31:0] tgt, rt;
    int idx;
    unc = kind inside {K_JMP_D, K_JMP_I, K_CALL_D, K_CALL_I, K_RET};
    cnd = kind inside {K_COND, K_CRET, K_CCALL};
    cal = kind inside {K_CALL_D, K_CALL_I, K_CCALL};
    ret = kind inside {K_RET, K_CRET};
    dir = kind inside {K_JMP_D, K_CALL_D, K_CCALL};
    @(negedge clk);
    reqValid = 1; reqPc = pc; directTarget = dt; reqAsid = as; reqTid = 1'(tid);
    reqSeq = 16'(seqCtr); dirTaken = dirT;
    isUncond = unc; isCond = cnd; isCall = cal; isReturn = ret; isDirect = dir;
    updValid = pUpd; updPc = pPc; updAsid = pAs; updTarget = pTg;
    #1;
    tk = unc ? 1'b1 : (cnd && dirT);
    if (ret && mCnt[tid] == 0) tk = 0;
    pop = 0; push = 0; idx = 0; rt = '0; tgt = '0;
    if (tk) begin
      if (ret) begin
        pop = 1; idx = mTop[tid]; rt = mStk[tid][idx]; tgt = rt;
      end else begin
        push = cal;
        if (cal && unc && dir) tgt = dt;
        else if (mHit(pc, as)) tgt = mTg[bIdx(pc)];
        else tk = 0;
      end
    end
    if (!tk) tgt = pc + 32'(INST_BYTES);
    chk({tag, " dir"}, 64'(predTaken), 64'(tk));
    chk({tag, " pc"}, 64'(predPc), 64'(tgt));
    chk({tag, " pop R4"}, 64'(histUsedRas), 64'(pop));
    chk({tag, " push R6"}, 64'(histPushedRas), 64'(push));
    chk({tag, " idx R9"}, 64'(histRasIdx), 64'(idx));
    chk({tag, " rt R12"}, 64'(histRasTarget), 64'(rt));
    chk({tag, " rec R12"}, {histValid, histTaken, histTid, histSeq, histPc},
        {1'b1, tk, 1'(tid), 16'(seqCtr), pc});
    // commit the model after the lookup of this cycle
    if (pop) begin
      mTop[tid] = (mTop[tid] + RAS_DEPTH - 1) % RAS_DEPTH;
      mCnt[tid]--;
    end else if (push) begin
      mTop[tid] = (mTop[tid] + 1) % RAS_DEPTH;
      mStk[tid][mTop[tid]] = pc;
      if (mCnt[tid] < RAS_DEPTH) mCnt[tid]++;
    end
    if (pUpd) begin
      mV[bIdx(pPc)] = 1; mPc[bIdx(pPc)] = pPc; mAs[bIdx(pPc)] = pAs; mTg[bIdx(pPc)] = pTg;
    end
    pUpd = 0;
    seqCtr++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int t = 0; t < THREADS; t++) begin mTop[t] = RAS_DEPTH - 1; mCnt[t] = 0; end
    for (int i = 0; i < BTB_ENTRIES; i++) mV[i] = 0;
    pPc = '0; pAs = '0; pTg = '0;
    rstN = 0; reqValid = 0; updValid = 0; reqPc = '0; directTarget = '0; reqAsid = '0;
    reqTid = '0; reqSeq = '0; dirTaken = 0; isUncond = 0; isCond = 0; isCall = 0;
    isReturn = 0; isDirect = 0; updPc = '0; updAsid = '0; updTarget = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 / R5: empty stacks and empty buffer after reset
    doReq("R1", K_RET, 32'h100, 0, 8'd1, 0, 1);
    chk("R5 empty return seq pc", 64'(predPc), 64'h104);
    doReq("R1", K_JMP_I, 32'h200, 0, 8'd1, 1, 1);
    chk("R1 buffer miss after reset", 64'(predTaken), 64'd0);

    // R11: write and lookup of same PC in one cycle
    setUpd(32'h300, 8'd5, 32'hAAA0);
    doReq("R11", K_JMP_I, 32'h300, 0, 8'd5, 0, 0);
    chk("R11 same-cycle sees old", 64'(predPc), 64'h304);
    doReq("R11", K_JMP_I, 32'h300, 0, 8'd5, 0, 0);
    chk("R11 next cycle hit, R2 dirTaken ignored", 64'(predPc), 64'hAAA0);

    // R8: asid and tag mismatch
    doReq("R8", K_JMP_I, 32'h300, 0, 8'd6, 0, 1);
    chk("R8 asid mismatch", 64'(predTaken), 64'd0);
    doReq("R8", K_JMP_I, 32'h400, 0, 8'd5, 0, 1);
    chk("R8 tag mismatch seq R10", 64'(predPc), 64'h404);

    // R3: conditional direction
    doReq("R3", K_COND, 32'h300, 0, 8'd5, 0, 0);
    chk("R3 cond not taken", 64'(predPc), 64'h304);
    doReq("R3", K_COND, 32'h300, 0, 8'd5, 0, 1);
    chk("R3 cond taken hit", 64'(predPc), 64'hAAA0);

    // R7: direct unconditional call ignores a conflicting buffer entry
    setUpd(32'h500, 8'd5, 32'hBBB0);
    doReq("R3", K_COND, 32'h600, 0, 8'd5, 0, 0);
    doReq("R7", K_CALL_D, 32'h500, 32'h7000, 8'd5, 0, 0);
    chk("R7 direct target", 64'(predPc), 64'h7000);

    // R4 / R9: pop returns the pushed PC from slot 0
    doReq("R4", K_RET, 32'h7000, 0, 8'd5, 0, 0);
    chk("R4 return target", 64'(predPc), 64'h500);
    chk("R9 first slot index", 64'(histRasIdx), 64'd0);

    // R6: indirect call missing the buffer still pushes
    doReq("R6", K_CALL_I, 32'h900, 0, 8'd5, 0, 1);
    chk("R6 demoted call pushed", {63'd0, histPushedRas}, 64'd1);
    chk("R6 demoted call not taken", 64'(predTaken), 64'd0);
    doReq("R6", K_RET, 32'h950, 0, 8'd5, 0, 1);
    chk("R6 pushed PC returned", 64'(predPc), 64'h900);

    // R9 / R13: overflow on thread 1, thread 0 untouched
    doReq("R13", K_CALL_D, 32'h2000, 32'h3000, 8'd1, 0, 0);
    for (int i = 0; i < 17; i++)
      doReq("R9", K_CALL_D, 32'h1000 + 32'(i * 8), 32'h8000, 8'd1, 1, 0);
    for (int i = 0; i < 16; i++) begin
      doReq("R9", K_RET, 32'h8000, 0, 8'd1, 1, 0);
      if (i == 0) chk("R9 newest after overflow", 64'(predPc), 64'h1080);
      if (i == 15) chk("R9 oldest overwritten", 64'(predPc), 64'h1008);
    end
    doReq("R9", K_RET, 32'h8000, 0, 8'd1, 1, 0);
    chk("R9 occupancy saturated at 16", 64'(predTaken), 64'd0);
    doReq("R13", K_RET, 32'h3000, 0, 8'd1, 0, 0);
    chk("R13 other thread intact", 64'(predPc), 64'h2000);
    idle();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int kind, tid;
      logic [31:0] pc;
      logic [7:0] as;
      string tag;
      kind = int'($urandom % 8);
      pc = (($urandom % 2) != 0 ? 32'h4100 : 32'h4000) + 32'(($urandom % 8) * 4);
      as = 8'(1 + $urandom % 2);
      tid = int'($urandom % 2);
      if (($urandom % 3) == 0)
        setUpd((($urandom % 2) != 0 ? 32'h4100 : 32'h4000) + 32'(($urandom % 8) * 4),
               8'(1 + $urandom % 2), {$urandom, 2'b00} >> 2 << 2);
      case (kind)
        K_COND, K_CCALL: tag = "R3";
        K_JMP_D, K_JMP_I: tag = "R8";
        K_CALL_D: tag = "R7";
        K_CALL_I: tag = "R6";
        default: tag = "R4";
      endcase
      doReq(tag, kind, pc, {$urandom} & 32'hFFFF_FFFC, as, tid, 1'($urandom % 2));
    end
    idle();

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule